// File: doc/BRIEF.md
# Dual-Sequence Byte Whitener

This block scrambles a byte stream for a packet radio data path by XORing each byte with a key byte drawn from a pseudo-random shift register. Two sequences are on offer. Sequence A is a 9-bit register that shifts towards bit 0. Sequence B is a 10-bit register that shifts towards its top bit. XOR with the same key stream undoes itself, so one instance serves the transmit side (whitening) and the receive side (de-whitening).

Bytes enter and leave over valid/ready streams. A byte is taken on the input when `in_valid` and `in_ready` are both high at a rising clock edge. It appears on the output one cycle later, held in a single output register. That register keeps its byte and stays valid until `out_ready` takes it. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. So a stall on the output reaches the input in the same cycle, and with `out_ready` held high one byte passes per clock. `pkt_start` and `mode_sel` are plain control pins that are looked at only together with an accepted byte.

Top module: `byte_whitener`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: With sequence A (`mode_sel`=0) the register is 9 bits wide and its seed is 0x1FF. The key byte is state bits [7:0]. One step takes f = bit0 XOR bit5, shifts the state right by one place and writes f into bit 8.
- R3: With sequence B (`mode_sel`=1) the register is 10 bits wide and its seed is 0x3FE. The key byte is state bits [9:2]. One step takes f = bit9 XOR bit4, ORs f into bit 0, then shifts the state left by one place and keeps 10 bits.
- R4: Each byte is XORed with the key formed from the state before that byte's steps. The state then moves on by eight steps before the next byte, so consecutive bytes use keys eight steps apart.
- R5: A byte accepted with `pkt_start` high uses the seed of the sequence chosen by `mode_sel` on that same byte. The first byte of any packet is therefore XORed with 0xFF in both sequences.
- R6: `pkt_start` high in a cycle with no accepted byte has no effect. The packet in progress keeps its sequence and state.
- R7: `mode_sel` is sampled only together with `pkt_start`. Changing it in the middle of a packet does not change the key stream.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` holds its value, `out_valid` stays high and `in_ready` is low.
- R9: With `out_ready` held high, a byte offered every cycle is accepted every cycle.
- R10: Passing a packet through the block twice, with the same sequence and a start strobe on each first byte, gives back the original bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 1 | Sequence choice, 0 = A, 1 = B; sampled with `pkt_start` |
| pkt_start | input | 1 | Marks the first byte of a packet; reloads the seed |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can take an input byte |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Whitened or de-whitened byte |
| out_ready | input | 1 | Sink takes the output byte |

## Verification
Long all-zero packets in each sequence expose the raw key stream. That separates the two variants and catches any error in taps, shift direction, window position or the eight-step advance. A sweep of all 256 byte values as single-byte packets in each sequence shows that the seed is applied to the strobed byte itself and that the data path is a plain XOR. Packets that raise a stray start strobe with no byte, or flip `mode_sel` halfway through, tell a correctly sampled control from one that leaks. A two-pass round trip under a stalling sink checks that the operation undoes itself and that stalls neither drop nor repeat bytes.

// File: rtl/whit_pkg.sv
package whit_pkg;

  // Key sequence selector, sampled at packet start.
  typedef enum logic {
    WH_SEQ_A = 1'b0,
    WH_SEQ_B = 1'b1
  } wh_seq_e;

endpackage

// File: rtl/whit_stepper.sv
// Key window and eight-step advance of one shift-register sequence.
module whit_stepper #(
  parameter int unsigned W     = 9,
  parameter int unsigned TAP   = 5,
  parameter bit          LEFT  = 1'b0,
  parameter int unsigned DW    = 8,
  parameter int unsigned STEPS = DW
) (
  input  logic [W-1:0]  state_i,
  output logic [DW-1:0] win_o,
  output logic [W-1:0]  next_o
);

  logic [STEPS:0][W-1:0] chain;

  assign chain[0] = state_i;

  for (genvar k = 0; k < STEPS; k++) begin : g_step
    if (LEFT) begin : g_left
      logic fb;
      assign fb           = chain[k][W-1] ^ chain[k][TAP];
      assign chain[k+1]   = {chain[k][W-2:1], chain[k][0] | fb, 1'b0};
    end else begin : g_right
      logic fb;
      assign fb           = chain[k][0] ^ chain[k][TAP];
      assign chain[k+1]   = {fb, chain[k][W-1:1]};
    end
  end

  if (LEFT) begin : g_win_hi
    assign win_o = state_i[W-1 -: DW];
  end else begin : g_win_lo
    assign win_o = state_i[DW-1:0];
  end

  assign next_o = chain[STEPS];

endmodule

// File: rtl/whit_seqstate.sv
// Holds the per-sequence register state and the packet's selected sequence.
module whit_seqstate
  import whit_pkg::*;
#(
  parameter int unsigned    AW     = 9,
  parameter int unsigned    BW     = 10,
  parameter logic [AW-1:0]  SEED_A = 9'h1FF,
  parameter logic [BW-1:0]  SEED_B = 10'h3FE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [AW-1:0] next_a_i,
  input  logic [BW-1:0] next_b_i,
  output wh_seq_e       seq_o,
  output logic [AW-1:0] cur_a_o,
  output logic [BW-1:0] cur_b_o
);

  wh_seq_e       seq_q;
  logic [AW-1:0] st_a_q;
  logic [BW-1:0] st_b_q;

  always_comb begin
    seq_o   = start_i ? wh_seq_e'(mode_i) : seq_q;
    cur_a_o = start_i ? SEED_A : st_a_q;
    cur_b_o = start_i ? SEED_B : st_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q  <= WH_SEQ_A;
      st_a_q <= SEED_A;
      st_b_q <= SEED_B;
    end else if (take_i) begin
      seq_q <= seq_o;
      if (seq_o == WH_SEQ_B) begin
        st_b_q <= next_b_i;
      end else begin
        st_a_q <= next_a_i;
      end
    end
  end

endmodule

// File: rtl/whit_outreg.sv
// Single output register with valid/ready hand-off.
module whit_outreg #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o,
  output logic          room_o
);

  assign room_o = !valid_o || ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      if (load_i) begin
        valid_o <= 1'b1;
        data_o  <= data_i;
      end else if (ready_i) begin
        valid_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/byte_whitener.sv
module byte_whitener
  import whit_pkg::*;
#(
  parameter int unsigned    DW     = 8,
  parameter int unsigned    AW     = 9,
  parameter int unsigned    BW     = 10,
  parameter int unsigned    A_TAP  = 5,
  parameter int unsigned    B_TAP  = 4,
  parameter logic [AW-1:0]  SEED_A = 9'h1FF,
  parameter logic [BW-1:0]  SEED_B = 10'h3FE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          pkt_start,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);

  localparam int unsigned STEPS = DW;

  logic          take;
  wh_seq_e       seq_cur;
  logic [AW-1:0] cur_a, next_a;
  logic [BW-1:0] cur_b, next_b;
  logic [DW-1:0] win_a, win_b, key, mixed;

  assign take = in_valid && in_ready;

  whit_seqstate #(
    .AW(AW), .BW(BW), .SEED_A(SEED_A), .SEED_B(SEED_B)
  ) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (take),
    .start_i  (pkt_start),
    .mode_i   (mode_sel),
    .next_a_i (next_a),
    .next_b_i (next_b),
    .seq_o    (seq_cur),
    .cur_a_o  (cur_a),
    .cur_b_o  (cur_b)
  );

  whit_stepper #(
    .W(AW), .TAP(A_TAP), .LEFT(1'b0), .DW(DW), .STEPS(STEPS)
  ) u_step_a (
    .state_i (cur_a),
    .win_o   (win_a),
    .next_o  (next_a)
  );

  whit_stepper #(
    .W(BW), .TAP(B_TAP), .LEFT(1'b1), .DW(DW), .STEPS(STEPS)
  ) u_step_b (
    .state_i (cur_b),
    .win_o   (win_b),
    .next_o  (next_b)
  );

  assign key   = (seq_cur == WH_SEQ_B) ? win_b : win_a;
  assign mixed = in_data ^ key;

  whit_outreg #(.DW(DW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (take),
    .data_i  (mixed),
    .ready_i (out_ready),
    .valid_o (out_valid),
    .data_o  (out_data),
    .room_o  (in_ready)
  );

endmodule

// File: rtl/whit_chk.sv
module whit_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pkt_start,
  input logic          in_valid,
  input logic [DW-1:0] in_data,
  input logic          in_ready,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          out_ready
);

  // R8: a stalled output byte is held
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R8: a stall blocks the input side
  p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R9: an accepted byte shows up on the next cycle
  p_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9: a drained register with no new byte goes empty
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !(in_valid && in_ready) |=> !out_valid);

  // R5: the first byte of a packet is XORed with the all-ones seed window
  p_seed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && pkt_start |=> out_data == ($past(in_data) ^ {DW{1'b1}}));

endmodule

bind byte_whitener whit_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pkt_start (pkt_start),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready)
);

// File: tb/sim_byte_whitener.sv
module sim_byte_whitener;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b0;
  logic       pkt_start = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b1;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int waits = 0;
  int bp_mode = 0;
  int bp_cnt = 0;

  logic [9:0] m_state = 10'h1FF;
  logic       m_mode = 1'b0;

  logic [7:0] expq[$];
  string      tagq[$];
  logic [7:0] rxq[$];

  bit         hold_pend = 1'b0;
  logic [7:0] hold_d = 8'h00;

  always #10 clk = ~clk;

  byte_whitener u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pkt_start(pkt_start),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Reference sequences computed from the stated step rules.
  function automatic logic [7:0] ref_win(input logic [9:0] s, input logic m);
    return m ? s[9:2] : s[7:0];
  endfunction

  function automatic logic [9:0] ref_adv(input logic [9:0] s, input logic m);
    logic [9:0] t = s;
    for (int i = 0; i < 8; i++) begin
      if (!m) begin
        t = {1'b0, t[0] ^ t[5], t[8:1]};
      end else begin
        t[0] = t[0] | (t[9] ^ t[4]);
        t    = {t[8:0], 1'b0};
      end
    end
    return t;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  // Sink: drives out_ready, checks bytes and stall behaviour.
  always @(negedge clk) begin
    if (rst_n) begin
      bp_cnt++;
      out_ready = (bp_mode == 0) ? 1'b1 : ((bp_cnt % 3) != 1);
      #1;
      if (hold_pend) begin
        chk(out_valid === 1'b1 && out_data === hold_d, "R8 hold", out_data, hold_d);
        hold_pend = 1'b0;
      end
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R9 unexpected byte", out_data, 0);
        end else begin
          chk(out_data === expq[0], tagq[0], out_data, expq[0]);
          void'(expq.pop_front());
          void'(tagq.pop_front());
        end
        rxq.push_back(out_data);
      end else if (out_valid) begin
        chk(in_ready === 1'b0, "R8 in_ready low on stall", in_ready, 0);
        hold_pend = 1'b1;
        hold_d    = out_data;
      end
    end
  end

  task automatic send(input logic [7:0] d, input bit sop, input logic m, input string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    in_data   = d;
    pkt_start = sop;
    mode_sel  = m;
    #2;
    while (!in_ready) begin
      waits++;
      @(negedge clk);
      #2;
    end
    if (sop) begin
      m_mode  = m;
      m_state = m ? 10'h3FE : 10'h1FF;
    end
    expq.push_back(d ^ ref_win(m_state, m_mode));
    tagq.push_back(tag);
    m_state = ref_adv(m_state, m_mode);
    @(posedge clk);
    #1;
    in_valid  = 1'b0;
    pkt_start = 1'b0;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  logic [7:0] orig[64];
  logic [7:0] pass1[64];

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(out_valid === 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready === 1'b1, "R1 in_ready after reset", in_ready, 1);
    rst_n = 1'b1;

    // Raw key stream, sequence A, full rate; also R4 and R9.
    waits = 0;
    send(8'h00, 1'b1, 1'b0, "R2 key A first");
    for (int i = 1; i < 64; i++) send(8'h00, 1'b0, 1'b0, "R2 R4 key A stream");
    drain();
    chk(waits == 0, "R9 no waits at full rate", waits, 0);

    // Raw key stream, sequence B.
    waits = 0;
    send(8'h00, 1'b1, 1'b1, "R3 key B first");
    for (int i = 1; i < 64; i++) send(8'h00, 1'b0, 1'b1, "R3 R4 key B stream");
    drain();
    chk(waits == 0, "R9 no waits at full rate B", waits, 0);

    // Every byte value as a one-byte packet, both sequences.
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 256; v++)
        send(8'(v), 1'b1, 1'(m), "R5 seed on strobed byte");
    drain();

    // Stray start strobe without a byte.
    send(8'h3C, 1'b1, 1'b1, "R6 before stray strobe");
    for (int i = 0; i < 5; i++) send(8'(i * 17), 1'b0, 1'b1, "R6 before stray strobe");
    @(negedge clk);
    pkt_start = 1'b1;
    mode_sel  = 1'b0;
    @(posedge clk);
    #1;
    pkt_start = 1'b0;
    for (int i = 0; i < 10; i++) send(8'(i * 29 + 3), 1'b0, 1'b1, "R6 after stray strobe");
    drain();

    // Mode flips mid-packet.
    send(8'h81, 1'b1, 1'b1, "R7 start B");
    for (int i = 0; i < 20; i++) send(8'(i * 11), 1'b0, 1'(i % 2), "R7 mode flip ignored");
    send(8'h81, 1'b1, 1'b0, "R7 start A");
    for (int i = 0; i < 20; i++) send(8'(i * 13), 1'b0, 1'b1, "R7 mode held A");
    drain();

    // Round trip under a stalling sink.
    bp_mode = 1;
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 64; i++) orig[i] = 8'(i * 37 + 5);
      rxq.delete();
      for (int i = 0; i < 64; i++) send(orig[i], i == 0, 1'(m), "R8 R10 pass one");
      drain();
      for (int i = 0; i < 64; i++) pass1[i] = rxq[i];
      rxq.delete();
      for (int i = 0; i < 64; i++) send(pass1[i], i == 0, 1'(m), "R8 R10 pass two");
      drain();
      chk(rxq.size() == 64, "R10 byte count", rxq.size(), 64);
      for (int i = 0; i < 64 && i < rxq.size(); i++)
        chk(rxq[i] === orig[i], "R10 round trip", rxq[i], orig[i]);
    end
    bp_mode = 0;
    drain();

    finish_run();
  end

endmodule